// File: doc/BRIEF.md
# Event Page Buffer Controller

This block allocates pages of an event memory in a data acquisition system that is driven by triggers. One page is always the active page, and the waveform memory writes into it. When a trigger is accepted, the active page is marked filled. The pointer then moves to the next free page, and the filled page number waits for an acknowledge from readout. Software returns pages to the pool with a free command. Acquisition runs only after a start command.

The block warns when the pool is down to its last free page. If a trigger arrives when no other page is free, acquisition halts and the block sets an error flag. Software must free pages and then issue start again. If a trigger is accepted while the previous page is still unacknowledged, the block flags a lost page. Four sticky flags feed one masked, registered interrupt line. A vector shows the filled or free state of every page.

Top module: `evpage_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all pages are free, the active page is 0, all flags are 0, acquisition is stopped, and `irq_o`, `free_busy_o` and `ack_valid_o` are 0.
- R2: `start_i` sets running at the next edge only when at least two pages are free (the active page and at least one other). Otherwise it is ignored.
- R3: A trigger while running, with at least two free pages, marks the active page filled. It moves the active page to the first free page found searching upward from active+1, with wrap-around, and sets flag bit 0.
- R4: If an accepted trigger leaves exactly one free page (the new active page), flag bit 1 is set in the same edge.
- R5: A trigger while running, with only the active page free, fills nothing and leaves the active page unchanged. It clears running and sets flag bit 7.
- R6: `ack_i` while a page is pending produces, one edge later, a single-cycle `ack_valid_o` with that page number on `ack_page_o`. `ack_i` with nothing pending is ignored.
- R7: If a trigger is accepted while a page is pending and `ack_i` is low in that cycle, flag bit 8 is set. The older page stays filled and is never delivered.
- R8: A free request is latched at one edge, and `free_busy_o` is 1 until the next edge. At that next edge the page is marked free if it was filled. A request for a page that is already free has no effect.
- R9: Flags are sticky and a 1 in `flag_clr_i` clears the matching bit. A flag set in the same cycle stays set. Bits 2 to 6 are always 0.
- R10: `irq_o` is 1 one edge after any of flag bits 0, 1, 7 or 8 is set together with its bit of `irq_mask_i`.
- R11: The pool size is the parameter `NPAGES` (default 64). A start from reset with no frees halts after exactly NPAGES-1 accepted triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or restart acquisition |
| trig_i | input | 1 | Trigger pulse |
| ack_i | input | 1 | Readout acknowledge of the pending page |
| free_req_i | input | 1 | Free-page command |
| free_page_i | input | PW | Page to free |
| flag_clr_i | input | 9 | Write-1-to-clear flag bits |
| irq_mask_i | input | 9 | Interrupt enable per flag bit |
| running_o | output | 1 | Acquisition running |
| cur_page_o | output | PW | Active page number |
| filled_o | output | NPAGES | Per-page filled state |
| flags_o | output | 9 | Sticky flags |
| irq_o | output | 1 | Page group interrupt |
| free_busy_o | output | 1 | Free operation in progress |
| ack_valid_o | output | 1 | Acknowledged page number valid |
| ack_page_o | output | PW | Acknowledged page number |

## Verification
Triggers, starts, acknowledges and flag clears show on the outputs one rising edge after the cycle in which they were driven. A free request shows as busy after one edge and as a cleared filled bit after the second edge. The interrupt follows a flag with one further edge of lag. The reference model in the bench steps on every rising edge from the same inputs. Every output is compared at the falling edge that follows, so each result is checked in the exact cycle it is due. Inputs change only after that comparison.

// File: rtl/evpage_pkg.sv
package evpage_pkg;
  localparam int FLAG_W = 9;
  localparam int F_NEXT = 0;
  localparam int F_WARN = 1;
  localparam int F_FULL = 7;
  localparam int F_LOST = 8;
  localparam logic [FLAG_W-1:0] GROUP_MASK = 9'h183;
endpackage

// File: rtl/pg_scan.sv
module pg_scan #(
  parameter int NPAGES = 64,
  localparam int PW = $clog2(NPAGES)
) (
  input  logic [NPAGES-1:0] filled_i,
  input  logic [PW-1:0]     cur_i,
  output logic [PW-1:0]     nxt_o,
  output logic [PW:0]       free_cnt_o
);
  logic [PW-1:0] idx;
  logic          found;

  always_comb begin
    free_cnt_o = '0;
    for (int i = 0; i < NPAGES; i++)
      free_cnt_o = free_cnt_o + (PW+1)'(~filled_i[i]);
  end

  // round-robin search starting just after the active page
  always_comb begin
    nxt_o = cur_i;
    found = 1'b0;
    idx   = '0;
    for (int i = 1; i < NPAGES; i++) begin
      idx = PW'((int'(cur_i) + i) % NPAGES);
      if (!found && !filled_i[idx]) begin
        nxt_o = idx;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pg_irq_flags.sv
module pg_irq_flags
  import evpage_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic [FLAG_W-1:0] mask_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flags_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= ((flags_q & ~clr_i) | set_i) & GROUP_MASK;
      irq_q   <= |(flags_q & mask_i & GROUP_MASK);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(flags_q) & ~$past(clr_i)) == ($past(flags_q) & ~$past(clr_i))));

  // R9
  unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q & ~GROUP_MASK) == '0);
endmodule

// File: rtl/evpage_ctrl.sv
module evpage_ctrl
  import evpage_pkg::*;
#(
  parameter int NPAGES = 64,
  localparam int PW = $clog2(NPAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              trig_i,
  input  logic              ack_i,
  input  logic              free_req_i,
  input  logic [PW-1:0]     free_page_i,
  input  logic [FLAG_W-1:0] flag_clr_i,
  input  logic [FLAG_W-1:0] irq_mask_i,
  output logic              running_o,
  output logic [PW-1:0]     cur_page_o,
  output logic [NPAGES-1:0] filled_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o,
  output logic              free_busy_o,
  output logic              ack_valid_o,
  output logic [PW-1:0]     ack_page_o
);
  logic [NPAGES-1:0] filled_q;
  logic [PW-1:0]     cur_q, nxt_page, pend_pg_q, fr_pg_q, ackpg_q;
  logic              run_q, pend_q, fr_v_q, ackv_q;
  logic [PW:0]       free_cnt;
  logic              trig_acc, has_room, adv, halt;
  logic [FLAG_W-1:0] flag_set;

  pg_scan #(.NPAGES(NPAGES)) u_scan (
    .filled_i   (filled_q),
    .cur_i      (cur_q),
    .nxt_o      (nxt_page),
    .free_cnt_o (free_cnt)
  );

  assign trig_acc = run_q && trig_i;
  assign has_room = free_cnt >= (PW+1)'(2);
  assign adv      = trig_acc && has_room;
  assign halt     = trig_acc && !has_room;

  always_comb begin
    flag_set         = '0;
    flag_set[F_NEXT] = adv;
    flag_set[F_WARN] = adv && (free_cnt == (PW+1)'(2));
    flag_set[F_FULL] = halt;
    flag_set[F_LOST] = adv && pend_q && !ack_i;
  end

  pg_irq_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (flag_set),
    .clr_i   (flag_clr_i),
    .mask_i  (irq_mask_i),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      filled_q  <= '0;
      cur_q     <= '0;
      run_q     <= 1'b0;
      pend_q    <= 1'b0;
      pend_pg_q <= '0;
      fr_v_q    <= 1'b0;
      fr_pg_q   <= '0;
      ackv_q    <= 1'b0;
      ackpg_q   <= '0;
    end else begin
      fr_v_q  <= free_req_i;
      fr_pg_q <= free_page_i;
      if (fr_v_q && filled_q[fr_pg_q])
        filled_q[fr_pg_q] <= 1'b0;
      if (adv) begin
        filled_q[cur_q] <= 1'b1;
        cur_q           <= nxt_page;
      end
      if (halt)
        run_q <= 1'b0;
      else if (start_i && has_room)
        run_q <= 1'b1;
      ackv_q <= ack_i && pend_q;
      if (ack_i && pend_q)
        ackpg_q <= pend_pg_q;
      if (adv) begin
        pend_q    <= 1'b1;
        pend_pg_q <= cur_q;
      end else if (ack_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign running_o   = run_q;
  assign cur_page_o  = cur_q;
  assign filled_o    = filled_q;
  assign free_busy_o = fr_v_q;
  assign ack_valid_o = ackv_q;
  assign ack_page_o  = ackpg_q;

  // R3
  adv_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && trig_i && free_cnt >= (PW+1)'(2)) |=> (filled_q[$past(cur_q)] && flags_o[F_NEXT]));

  // R3
  active_free_chk: assert property (@(posedge clk) disable iff (rst)
    !filled_q[cur_q]);

  // R5
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && trig_i && free_cnt < (PW+1)'(2)) |=> (!run_q && flags_o[F_FULL] && $stable(cur_q)));

  // R6
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && pend_q) |=> (ack_valid_o && ack_page_o == $past(pend_pg_q)));

  // R8
  free_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (fr_v_q && filled_q[fr_pg_q]) |=> !filled_q[$past(fr_pg_q)]);
endmodule

// File: tb/sim_evpage_ctrl.sv
module sim_evpage_ctrl;
  localparam int NP = 64;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, start_i = 0, trig_i = 0, ack_i = 0, free_req_i = 0;
  logic [PW-1:0] free_page_i = '0;
  logic [8:0]    flag_clr_i = '0, irq_mask_i = '0;
  logic          running_o, irq_o, free_busy_o, ack_valid_o;
  logic [PW-1:0] cur_page_o, ack_page_o;
  logic [NP-1:0] filled_o;
  logic [8:0]    flags_o;

  evpage_ctrl #(.NPAGES(NP)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .trig_i(trig_i), .ack_i(ack_i),
    .free_req_i(free_req_i), .free_page_i(free_page_i), .flag_clr_i(flag_clr_i),
    .irq_mask_i(irq_mask_i), .running_o(running_o), .cur_page_o(cur_page_o),
    .filled_o(filled_o), .flags_o(flags_o), .irq_o(irq_o), .free_busy_o(free_busy_o),
    .ack_valid_o(ack_valid_o), .ack_page_o(ack_page_o)
  );

  // behavioural reference model
  bit   m_filled[NP];
  int   m_cur, m_frpg, m_ackpg;
  bit   m_run, m_frv, m_irq, m_ackv;
  bit [8:0] m_flags;
  int   m_pendq[$];

  int checks = 0, fails = 0, cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      foreach (m_filled[i]) m_filled[i] = 0;
      m_cur = 0; m_run = 0; m_frv = 0; m_frpg = 0; m_irq = 0;
      m_ackv = 0; m_ackpg = 0; m_flags = '0; m_pendq.delete();
    end else begin
      int fc, nf, ci;
      bit had_pend, lost;
      bit [8:0] set;
      fc = 0;
      foreach (m_filled[i]) if (!m_filled[i]) fc++;
      nf = m_cur;
      for (int i = NP - 1; i >= 1; i--) if (!m_filled[(m_cur + i) % NP]) nf = (m_cur + i) % NP;
      set = '0;
      m_irq = |(m_flags & irq_mask_i & 9'h183);
      had_pend = m_pendq.size() > 0;
      lost = had_pend && !ack_i;
      m_ackv = ack_i && had_pend;
      if (m_ackv) m_ackpg = m_pendq.pop_front();
      if (m_frv && m_filled[m_frpg]) m_filled[m_frpg] = 0;
      if (m_run && trig_i) begin
        if (fc >= 2) begin
          ci = m_cur;
          m_filled[ci] = 1;
          set[0] = 1;
          if (fc == 2) set[1] = 1;
          if (lost) set[8] = 1;
          m_pendq.delete();
          m_pendq.push_back(ci);
          m_cur = nf;
        end else begin
          m_run = 0;
          set[7] = 1;
        end
      end else if (start_i && fc >= 2) begin
        m_run = 1;
      end
      m_flags = (m_flags & ~flag_clr_i) | set;
      m_frv = free_req_i;
      m_frpg = int'(free_page_i);
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [NP-1:0] model_vec();
    logic [NP-1:0] v;
    foreach (m_filled[i]) v[i] = m_filled[i];
    return v;
  endfunction

  task automatic compare();
    chk("R3 filled", 64'(filled_o), 64'(model_vec()));
    chk("R3 active page", 64'(cur_page_o), 64'(m_cur));
    chk("R5 running", 64'(running_o), 64'(m_run));
    chk("R9 flags", 64'(flags_o), 64'(m_flags));
    chk("R10 irq", 64'(irq_o), 64'(m_irq));
    chk("R8 busy", 64'(free_busy_o), 64'(m_frv));
    chk("R6 ack valid", 64'(ack_valid_o), 64'(m_ackv));
    if (m_ackv) chk("R6 ack page", 64'(ack_page_o), 64'(m_ackpg));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    start_i = 0; trig_i = 0; ack_i = 0; free_req_i = 0; flag_clr_i = '0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int ntrig;
    int firstpg;
    irq_mask_i = 9'h1ff;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 filled", 64'(filled_o), 64'd0);
    chk("R1 page", 64'(cur_page_o), 64'd0);
    chk("R1 flags", 64'(flags_o), 64'd0);
    chk("R1 running", 64'(running_o), 64'd0);
    // trigger while stopped is ignored (R2)
    trig_i = 1; tick(); idle(); tick();
    chk("R2 stopped trigger", 64'(filled_o), 64'd0);
    start_i = 1; tick(); idle();
    chk("R2 start", 64'(running_o), 64'd1);
    // fill the whole pool, acknowledging each previous page (R11, R4, R5)
    ntrig = 0;
    while (running_o && ntrig < 2 * NP) begin
      if (filled_o != '0 || ntrig > 0) ack_i = 1;
      trig_i = 1; tick(); idle();
      if (running_o) ntrig++;
    end
    chk("R11 triggers to full", 64'(ntrig), 64'(NP - 1));
    chk("R4 warn flag", 64'(flags_o[1]), 64'd1);
    chk("R5 error flag", 64'(flags_o[7]), 64'd1);
    chk("R7 no lost with acks", 64'(flags_o[8]), 64'd0);
    chk("R11 filled count", 64'($countones(filled_o)), 64'(NP - 1));
    tick(); tick();
    // start on full pool ignored (R2)
    start_i = 1; tick(); idle();
    chk("R2 start when full", 64'(running_o), 64'd0);
    // free the active (free) page: ignored (R8)
    free_req_i = 1; free_page_i = cur_page_o; tick(); idle(); tick();
    chk("R8 free of free page", 64'($countones(filled_o)), 64'(NP - 1));
    free_req_i = 1; free_page_i = 6'd5; tick(); idle();
    chk("R8 busy", 64'(free_busy_o), 64'd1);
    tick();
    chk("R8 cleared", 64'(filled_o[5]), 64'd0);
    chk("R8 busy done", 64'(free_busy_o), 64'd0);
    // R9 write-one clear of all flags
    flag_clr_i = 9'h1ff; tick(); idle();
    chk("R9 clear", 64'(flags_o), 64'd0);
    tick();
    chk("R10 irq idle", 64'(irq_o), 64'd0);
    free_req_i = 1; free_page_i = 6'd9; tick(); free_page_i = 6'd10; tick(); idle(); tick();
    start_i = 1; tick(); idle();
    chk("R2 restart", 64'(running_o), 64'd1);
    // two triggers without acknowledge -> lost (R7)
    firstpg = int'(cur_page_o);
    trig_i = 1; tick(); tick(); idle();
    chk("R7 lost flag", 64'(flags_o[8]), 64'd1);
    chk("R7 old page kept", 64'(filled_o[firstpg]), 64'd1);
    ack_i = 1; tick(); idle();
    chk("R6 ack delivers latest", 64'(ack_page_o == 6'(firstpg)), 64'd0);
    ack_i = 1; tick(); idle();
    chk("R6 ack with none pending", 64'(ack_valid_o), 64'd0);
    // random phase
    for (int c = 0; c < 6000; c++) begin
      trig_i     = ($urandom % 3) == 0;
      ack_i      = ($urandom % 3) == 0;
      free_req_i = ($urandom % 3) == 0;
      free_page_i = 6'($urandom);
      start_i    = ($urandom % 12) == 0;
      flag_clr_i = (($urandom % 8) == 0) ? 9'($urandom) : '0;
      if (($urandom % 50) == 0) irq_mask_i = 9'($urandom);
      rst = (c == 3000);
      tick();
    end
    idle(); rst = 0;
    tick();
    finish_run();
  end
endmodule